// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control core of a pipelined burst SRAM with a shared data bus and 32-bit words. Every control input is sampled on the rising clock edge. Two active-low address strobes start an access. The primary strobe wins when both are asserted. The primary strobe is also gated by the first chip enable. Three chip enables decide whether a strobe selects or deselects the block.

Reads pass through a registered output stage. The bus driver enable follows a double-cycle-deselect pipeline, so a deselect reaches the data bus one clock later than it reaches the access logic.

Writes reach a behavioural array that has four byte lanes. A write started by the secondary strobe completes on the edge that carries it. A write started by the primary strobe takes effect on the following edge. After an access starts, cycles without a strobe continue the burst. A step input moves the two low address bits forward, wrapping within a group of four.

Top module: `psram_ctrl`

## Requirements
- R1: A strobe selects the block only when en_a_n is 0, en_b is 1 and en_c_n is 0. A strobe that arrives with any chip enable inactive deselects the block, and writes nothing.
- R2: For a read whose address is registered at edge N, the data of that word is on dout after edge N+1. dq_oe is 1 from then on, provided drive_n is 0.
- R3: When req_pri_n and req_sec_n are both 0 on a selecting edge, the primary strobe is acted on and the access is a read. The write inputs are ignored on that edge.
- R4: req_pri_n is ignored while en_a_n is 1. In that case the cycle loads no address: it either continues the current burst or, when req_sec_n is 0, deselects.
- R5: A primary-strobe access ignores the write inputs on its first edge. If the write inputs are active on the next edge, which has no strobe, the data is written to the loaded address.
- R6: A secondary-strobe write with req_pri_n at 1 writes din on the same edge, using the write inputs sampled on that edge.
- R7: With all_wr_n at 0, all four lanes are written, whatever lane_wr_n and lane_sel_n are.
- R8: With all_wr_n at 1, lane i (din bits 8i+7..8i, selected by lane_sel_n[i]) is written only when lane_wr_n is 0 and lane_sel_n[i] is 0. Every other lane keeps its value. lane_sel_n alone, with lane_wr_n at 1, writes nothing.
- R9: After any write edge, dq_oe is 0 for that cycle, whatever drive_n is.
- R10: When a deselect is registered at edge N, dq_oe may still be 1 between N and N+1 and is 0 after edge N+1.
- R11: In the first cycle of an access that follows a deselected state, dq_oe is 0 whatever drive_n is.
- R12: In a continuation cycle, step_n at 0 adds one to the two low address bits, wrapping 3 to 0 and leaving the upper bits unchanged. step_n at 1 keeps the address. step_n has no effect on a strobe edge.
- R13: drive_n at 1 forces dq_oe to 0 without waiting for a clock. A synchronous reset with rst_n at 0 leaves the block deselected, with dq_oe at 0 and the array cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pri_n | input | 1 | Primary address strobe, active low, gated by en_a_n |
| req_sec_n | input | 1 | Secondary address strobe, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | 4 | Lane selects, active low, bit i for byte i |
| drive_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| dq_oe | output | 1 | Data bus driver enable |

## Verification
On every cycle, assertions check that dq_oe stays low after a write edge and in the first cycle after a selecting read from the deselected state. They also check that it falls one edge after a deselect, that the primary strobe wins over the secondary one, that a gated primary strobe loads no address, and that a burst step keeps the upper address bits. Only the bench scenarios, compared against a word-level scoreboard, can show that the right word returns with the right latency. The same holds for the lane merge of partial writes, for the second-edge timing of primary-strobe writes, and for the wrap order of a burst.

// File: rtl/psram_pkg.sv
// Shared types for the burst SRAM controller.
// Assumes: one access decision per clock edge.
package psram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_DESEL = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_t;

endpackage

// File: rtl/psram_decode.sv
// Access decode: turns strobes, chip enables and write controls into one
// access kind per edge, plus address-load, advance and lane write mask.
// Assumes: sel_q is the registered "block selected" state from the top.
module psram_decode
    import psram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pri_n,
    input  logic             req_sec_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             sel_q,
    output acc_kind_t        kind,
    output logic             load,
    output logic             adv_go,
    output logic [LANES-1:0] lane_mask
);

    logic en_ok;
    logic pri_act;
    logic strobe;
    logic wr_ctl;

    // Qualify strobes and classify the write controls.
    always_comb begin
        en_ok   = !en_a_n && en_b && !en_c_n;
        pri_act = !req_pri_n && !en_a_n;
        strobe  = pri_act || !req_sec_n;
        wr_ctl  = !all_wr_n || !lane_wr_n;
    end

    // Pick the access kind for this edge.
    always_comb begin
        kind   = ACC_IDLE;
        load   = 1'b0;
        adv_go = 1'b0;
        if (strobe) begin
            if (!en_ok) begin
                kind = ACC_DESEL;
            end else begin
                load = 1'b1;
                kind = (pri_act || !wr_ctl) ? ACC_READ : ACC_WRITE;
            end
        end else if (sel_q) begin
            adv_go = !step_n;
            kind   = wr_ctl ? ACC_WRITE : ACC_READ;
        end
    end

    // Lane mask: global write covers every lane, else per-lane selects.
    always_comb begin
        if (!all_wr_n) begin
            lane_mask = '1;
        end else if (!lane_wr_n) begin
            lane_mask = ~lane_sel_n;
        end else begin
            lane_mask = '0;
        end
    end

    // R3: both strobes on a selecting edge give a primary read
    p_pri_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pri_n && !req_sec_n && !en_a_n && en_b && !en_c_n)
            |-> (kind == ACC_READ && load));

    // R4: primary strobe gated by en_a_n never loads an address by itself
    p_pri_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n && req_sec_n) |-> !load);

endmodule

// File: rtl/psram_burst_addr.sv
// Burst address: holds the current access address, loads it on a strobe,
// and steps the low BB bits with wraparound on continuation cycles.
// Assumes: AW > BB; commit is high only for read and write accesses.
module psram_burst_addr #(
    parameter int AW = 8,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          load,
    input  logic          adv_go,
    input  logic          commit,
    output logic [AW-1:0] acc_addr
);

    logic [AW-1:0] cur_q;
    logic [BB-1:0] low_next;

    // Next low bits, wrapping within the burst group.
    always_comb begin
        low_next = cur_q[BB-1:0] + BB'(1);
    end

    // Address used by the access on this edge.
    always_comb begin
        if (load) begin
            acc_addr = addr_in;
        end else if (adv_go) begin
            acc_addr = {cur_q[AW-1:BB], low_next};
        end else begin
            acc_addr = cur_q;
        end
    end

    // Remember the address of every committed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (commit) begin
            cur_q <= acc_addr;
        end
    end

    // R12: a burst step never touches the upper address bits
    p_step_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !load && adv_go) |=> (cur_q[AW-1:BB] == $past(cur_q[AW-1:BB])));

endmodule

// File: rtl/psram_lane_array.sv
// Behavioural word array split into byte lanes, with one write enable per
// lane, a combinational read port, and a synchronous clear on reset.
// Assumes: depth 2**AW stays small (behavioural model).
module psram_lane_array #(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    lane_we,
    input  logic [AW-1:0]       wr_addr,
    input  logic [LANES*LW-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [LANES*LW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Clear on reset, otherwise write this lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= '0;
                end
            end else if (lane_we[g]) begin
                mem[wr_addr] <= wr_data[g*LW +: LW];
            end
        end

        // Read this lane of the addressed word.
        always_comb begin
            rd_data[g*LW +: LW] = mem[rd_addr];
        end
    end

endmodule

// File: rtl/psram_read_pipe.sv
// Read path: stage 1 registers the access, stage 2 registers the word and
// the output-active flag; the bus enable is masked after writes and by the
// asynchronous drive_n. A deselect therefore reaches the bus one edge late.
// Assumes: rd_word is the array word at rd_addr.
module psram_read_pipe
    import psram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_kind_t     kind,
    input  logic [AW-1:0] acc_addr,
    input  logic          drive_n,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout,
    output logic          dq_oe
);

    logic          rv_q;
    logic          wr_q;
    logic          act_q;
    logic [AW-1:0] ra_q;
    logic [DW-1:0] dout_q;

    // Stage 1: register the access kind and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
            wr_q <= 1'b0;
            ra_q <= '0;
        end else begin
            rv_q <= (kind == ACC_READ);
            wr_q <= (kind == ACC_WRITE);
            ra_q <= acc_addr;
        end
    end

    // Stage 2: capture read data and the pipelined output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            act_q <= rv_q;
            if (rv_q) begin
                dout_q <= rd_word;
            end
        end
    end

    // Drive the bus enable and data outputs.
    always_comb begin
        rd_addr = ra_q;
        dout    = dout_q;
        dq_oe   = act_q && !drive_n && !wr_q;
    end

    // R9: no bus drive in the cycle after a write edge
    p_wr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE) |=> !dq_oe);

    // R10: bus released one edge after a registered deselect
    p_dcd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DESEL) |=> ##1 !act_q);

    // R13: asynchronous output enable gates the bus
    p_oe_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        drive_n |-> !dq_oe);

endmodule

// File: rtl/psram_ctrl.sv
// Top of the pipelined burst SRAM controller: decode, burst address,
// lane array and read pipeline, plus the registered selection state.
// Assumes: all control inputs synchronous to clk except drive_n.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 8,
    parameter int BB    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_pri_n,
    input  logic                req_sec_n,
    input  logic                en_a_n,
    input  logic                en_b,
    input  logic                en_c_n,
    input  logic                step_n,
    input  logic                all_wr_n,
    input  logic                lane_wr_n,
    input  logic [LANES-1:0]    lane_sel_n,
    input  logic                drive_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] din,
    output logic [LANES*LW-1:0] dout,
    output logic                dq_oe
);

    localparam int DW = LANES * LW;

    acc_kind_t        kind;
    logic             load;
    logic             adv_go;
    logic             commit;
    logic             sel_q;
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_word;

    psram_decode #(.LANES(LANES)) decode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pri_n  (req_pri_n),
        .req_sec_n  (req_sec_n),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .step_n     (step_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .sel_q      (sel_q),
        .kind       (kind),
        .load       (load),
        .adv_go     (adv_go),
        .lane_mask  (lane_mask)
    );

    // Commit and lane enables follow the decoded access kind.
    always_comb begin
        commit  = (kind == ACC_READ) || (kind == ACC_WRITE);
        lane_we = (kind == ACC_WRITE) ? lane_mask : '0;
    end

    // Selection state: set by a selecting strobe, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (kind == ACC_DESEL) begin
            sel_q <= 1'b0;
        end else if (load) begin
            sel_q <= 1'b1;
        end
    end

    psram_burst_addr #(.AW(AW), .BB(BB)) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (addr),
        .load     (load),
        .adv_go   (adv_go),
        .commit   (commit),
        .acc_addr (acc_addr)
    );

    psram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .wr_addr (acc_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    psram_read_pipe #(.AW(AW), .DW(DW)) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .acc_addr (acc_addr),
        .drive_n  (drive_n),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .dout     (dout),
        .dq_oe    (dq_oe)
    );

    // R11: first cycle of an access out of the deselected state is not driven
    p_first_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ && !sel_q) |=> !dq_oe);

    // R1: a strobe with a chip enable inactive never writes a lane
    p_desel_nowr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DESEL) |-> (lane_we == '0));

endmodule

// File: tb/psram_ctrl_tb.sv
// Bench for psram_ctrl: directed corner cases, then seeded random traffic,
// all checked against a word-level scoreboard model.
module psram_ctrl_tb_top;

    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_pri_n = 1'b1;
    logic        req_sec_n = 1'b1;
    logic        en_a_n = 1'b0;
    logic        en_b = 1'b1;
    logic        en_c_n = 1'b0;
    logic        step_n = 1'b1;
    logic        all_wr_n = 1'b1;
    logic        lane_wr_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic        drive_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] din = 32'h0;
    logic [31:0] dout;
    logic        dq_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // scoreboard state
    logic [31:0] mm [DEPTH];
    bit          m_sel;
    logic [7:0]  m_cur;
    bit          m_rv;
    bit          m_wrq;
    bit          m_act;
    logic [7:0]  m_ra;
    logic [31:0] m_dout;

    always #10 clk = ~clk;

    psram_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pri_n  (req_pri_n),
        .req_sec_n  (req_sec_n),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .step_n     (step_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .drive_n    (drive_n),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dq_oe      (dq_oe)
    );

    // Access kind from the requirements: 0 idle, 1 deselect, 2 read, 3 write.
    function automatic int exp_kind(bit sel, bit p_n, bit s_n, bit a_n, bit b,
                                    bit c_n, bit aw_n, bit lw_n);
        bit pact = !p_n && !a_n;
        bit strb = pact || !s_n;
        bit wctl = !aw_n || !lw_n;
        if (strb) begin
            if (a_n || !b || c_n) return 1;
            if (pact || !wctl) return 2;
            return 3;
        end
        if (sel) return wctl ? 3 : 2;
        return 0;
    endfunction

    function automatic logic [3:0] exp_mask(bit aw_n, bit lw_n, logic [3:0] s_n);
        if (!aw_n) return 4'hF;
        if (!lw_n) return ~s_n;
        return 4'h0;
    endfunction

    function automatic logic [7:0] exp_addr(bit ld, bit adv, logic [7:0] cur,
                                            logic [7:0] a);
        if (ld) return a;
        if (adv) return {cur[7:2], cur[1:0] + 2'd1};
        return cur;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update the model at the edge, then compare at edge + 5 ns.
    task automatic step(string tag_en, string tag_dat);
        int         k;
        bit         ld;
        logic [7:0] a;
        logic [3:0] msk;
        bit         exp_en;
        k   = exp_kind(m_sel, req_pri_n, req_sec_n, en_a_n, en_b, en_c_n,
                       all_wr_n, lane_wr_n);
        ld  = (k >= 2) && (!req_sec_n || (!req_pri_n && !en_a_n));
        a   = exp_addr(ld, (k >= 2) && !ld && !step_n, m_cur, addr);
        msk = exp_mask(all_wr_n, lane_wr_n, lane_sel_n);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mm[i] = 32'h0;
            m_sel = 0; m_cur = 8'h0; m_rv = 0; m_wrq = 0; m_act = 0;
            m_ra = 8'h0; m_dout = 32'h0;
        end else begin
            if (m_rv) m_dout = mm[m_ra];
            m_act = m_rv;
            m_rv  = (k == 2);
            m_wrq = (k == 3);
            m_ra  = a;
            if (k == 3) begin
                for (int l = 0; l < 4; l++)
                    if (msk[l]) mm[a][l*8 +: 8] = din[l*8 +: 8];
            end
            if (k == 1) m_sel = 0;
            else if (ld) m_sel = 1;
            if (k >= 2) m_cur = a;
        end
        #5;
        exp_en = m_act && !drive_n && !m_wrq;
        check(tag_en, {31'h0, dq_oe}, {31'h0, exp_en});
        if (exp_en && dq_oe) check(tag_dat, dout, m_dout);
    endtask

    task automatic set_idle();
        req_pri_n = 1; req_sec_n = 1; en_a_n = 0; en_b = 1; en_c_n = 0;
        step_n = 1; all_wr_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF; drive_n = 0;
    endtask

    task automatic sec_write(logic [7:0] a, logic [31:0] d, bit aw_n, bit lw_n,
                             logic [3:0] s_n, string tag);
        set_idle();
        req_sec_n = 0; addr = a; din = d;
        all_wr_n = aw_n; lane_wr_n = lw_n; lane_sel_n = s_n;
        step("R9 enable after write edge", tag);
    endtask

    task automatic sec_read(logic [7:0] a, string tag);
        set_idle();
        req_sec_n = 0; addr = a;
        step("R2 read enable", tag);
        set_idle();
        step("R2 read enable", tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) mm[i] = 32'h0;
        // reset state (R13)
        repeat (3) step("R13 reset dq_oe", "R13 reset data");
        rst_n = 1;
        set_idle();
        step("R13 idle after reset", "R13 data");

        // R6/R7: single-edge secondary write of all lanes, then read back
        sec_write(8'h10, 32'hA1B2C3D4, 0, 1, 4'hF, "R7 global write");
        sec_read(8'h10, "R6 secondary write data");
        // R8: lanes 0 and 2 only
        sec_write(8'h10, 32'h11223344, 1, 0, 4'b1010, "R8 lane write");
        sec_read(8'h10, "R8 lane merge");
        // R8: selects without lane write enable write nothing
        sec_write(8'h10, 32'hFFFFFFFF, 1, 1, 4'h0, "R8 no lane enable");
        step("R8 enable", "R8 selects alone write nothing");

        // R5: primary write lands on the second edge
        set_idle(); req_pri_n = 0; addr = 8'h20; din = 32'hDEAD0000;
        step("R5 first edge", "R5 data");
        set_idle(); all_wr_n = 0; din = 32'h5A5A1234; addr = 8'h77;
        step("R9 after primary write", "R5 data");
        sec_read(8'h20, "R5 primary write data");
        // R5: write inputs on the first primary edge are ignored
        set_idle(); req_pri_n = 0; addr = 8'h21; all_wr_n = 0; din = 32'hBAD0BAD0;
        step("R5 first edge ignored", "R5 data");
        set_idle();
        step("R5 enable", "R5 first-edge write ignored");
        step("R5 enable", "R5 first-edge write ignored");

        // R3: both strobes with write inputs active -> primary read
        set_idle(); req_pri_n = 0; req_sec_n = 0; addr = 8'h30;
        all_wr_n = 0; din = 32'hCAFEF00D;
        step("R3 priority enable", "R3 data");
        set_idle();
        step("R3 priority enable", "R3 primary read, no write");
        sec_read(8'h30, "R3 word untouched");

        // R4: primary strobe with en_a_n high continues the burst at 0x10
        sec_read(8'h10, "R4 setup");
        set_idle(); req_pri_n = 0; en_a_n = 1; addr = 8'h55;
        step("R4 gated primary", "R4 data");
        set_idle();
        step("R4 gated primary", "R4 no address load");
        // R4: secondary strobe with en_a_n high deselects
        set_idle(); req_sec_n = 0; en_a_n = 1;
        step("R10 enable still on after deselect", "R4 data");
        set_idle();
        step("R10 enable off one edge later", "R10 data");

        // R11: first access after deselect is not driven
        set_idle(); req_sec_n = 0; addr = 8'h10;
        step("R11 first cycle off", "R11 data");
        set_idle();
        step("R11 second cycle on", "R11 data");
        // R1: a chip enable inactive deselects (en_c_n), nothing written
        set_idle(); req_sec_n = 0; en_c_n = 1; all_wr_n = 0; addr = 8'h10;
        din = 32'h0BADBEEF;
        step("R1 deselect enable", "R1 data");
        set_idle(); req_sec_n = 0; en_b = 0;
        step("R1 deselect enable", "R1 data");
        sec_read(8'h10, "R1 deselect wrote nothing");

        // R12: burst with wraparound
        for (int i = 0; i < 4; i++)
            sec_write(8'h40 + 8'(i), 32'h40400000 + 32'(i), 0, 1, 4'hF, "R12 fill");
        set_idle(); req_sec_n = 0; addr = 8'h42; step_n = 0;
        step("R12 strobe ignores step", "R12 data");
        set_idle(); step_n = 0;
        step("R12 enable", "R12 start word");
        step("R12 enable", "R12 step to 3");
        step("R12 enable", "R12 wrap to 0");
        step_n = 1;
        step("R12 enable", "R12 step to 1");
        step("R12 enable", "R12 hold");
        // R13: drive_n high removes the bus drive at once
        drive_n = 1;
        step("R13 drive_n high", "R13 data");
        drive_n = 0;
        step("R13 drive_n low again", "R13 data");

        // seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            req_pri_n  = ($urandom_range(3) != 0);
            req_sec_n  = ($urandom_range(2) != 0);
            en_a_n     = ($urandom_range(7) == 0);
            en_b       = ($urandom_range(7) != 0);
            en_c_n     = ($urandom_range(7) == 0);
            step_n     = ($urandom_range(1) != 0);
            all_wr_n   = ($urandom_range(3) != 0);
            lane_wr_n  = ($urandom_range(2) != 0);
            lane_sel_n = 4'($urandom_range(15));
            drive_n    = ($urandom_range(4) == 0);
            addr       = 8'($urandom_range(31));
            din        = $urandom;
            step("R9 R10 R11 random enable", "R2 random data");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule